// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This engine takes an incoming frame one byte at a time and stores it into memory buffers that software describes in a ring of 8-byte receive descriptors. Four bytes of Ethernet CRC-32, computed over the frame, follow the frame data in the stored stream. Each buffer is filled up to a programmable byte cap. When a buffer closes, the engine writes its length and updated flags back into the descriptor, then moves to the next descriptor or wraps to the ring base.

Software points the engine at the ring base, enables it and issues a receive demand. The engine then reads the current descriptor and reports through `rx_active` whether that descriptor can take a frame. Frames are accepted only while `rx_active` is high. After each frame the engine looks at the next descriptor again and sets `rx_active` from what it finds. Two length checks apply to every frame: a hard cap on the stored size (a build parameter), and a softer limit that is programmable at run time.

A descriptor is two little-endian 32-bit words. Word 0 holds the length in bits 15:0 and the flags in bits 31:16. Word 1 holds the byte address of the buffer.

Top module: `rxr_ring_engine`

## Requirements
- R1: The stored byte stream is the frame bytes in order, followed by the frame's CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, result inverted). The CRC is stored most significant byte first. Bytes go to consecutive addresses starting at the buffer address in word 1.
- R2: A buffer takes at most `{buf_max[10:4], 4'b0}` bytes, because the other bits of `buf_max` are ignored. A full buffer closes and filling continues in the next descriptor, so the CRC bytes may be split across the last two buffers.
- R3: Closing a buffer writes word 0 of its descriptor. Bits 15:0 receive the number of bytes stored in that buffer. In the flags (bits 31:16), the empty flag (flag bit 15) is cleared and all other existing flag bits are kept.
- R4: The final buffer of a frame also gets the last flag (flag bit 11) and pulses `evt_frame` for one cycle. Every other buffer pulses `evt_buf` for one cycle and gets no last flag.
- R5: If the stored size (frame length plus 4) exceeds MAX_FRAME, only MAX_FRAME bytes are stored and the rest of the frame is consumed and discarded. The final descriptor then gets both the truncated flag (flag bit 0) and the length-error flag (flag bit 5). A stored size equal to MAX_FRAME is not truncated.
- R6: If the stored size exceeds `len_limit`, the final descriptor gets the length-error flag (flag bit 5) without the truncated flag. A size equal to the limit sets no flag.
- R7: The descriptor after the current one is at the ring base when the current descriptor's wrap flag (flag bit 13) is set. Otherwise it is 8 bytes further on.
- R8: If the engine meets a descriptor without the empty flag in the middle of a frame, it stops storing. The rest of the frame is consumed and discarded, that descriptor is left untouched, no further event is raised, and `rx_active` falls.
- R9: After a frame, `rx_active` is high only if the next descriptor has the empty flag set.
- R10: A `rx_demand` pulse reads the current descriptor and sets `rx_active` from its empty flag, but only while `ctrl_en` is high and `rx_active` is low. Otherwise the pulse has no effect.
- R11: While `ctrl_en` is low, `rx_active` is low from the next cycle on.
- R12: After reset, `rx_active` and both events are low and the current descriptor is address 0. `ring_set` loads the ring base into the current descriptor. `in_ready` stays low unless a frame is being stored or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable |
| rx_demand | input | 1 | Receive-demand pulse |
| ring_set | input | 1 | Load the ring base into the current-descriptor pointer (applied when idle) |
| ring_base | input | AW | Ring base byte address (bits 1:0 ignored) |
| buf_max | input | 16 | Buffer size value; only bits 10:4 are used |
| len_limit | input | 16 | Programmable frame length limit |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Frame byte accepted in this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| evt_buf | output | 1 | Pulse: a non-final buffer was closed |
| evt_frame | output | 1 | Pulse: the final buffer of a frame was closed |
| rx_active | output | 1 | The current descriptor is known to be empty |

## Verification
A stale or miscounted stored-byte counter shows up as a wrong length or error flag in the final descriptor, in the cycle that descriptor is written back. It also shows up as truncation at the wrong byte, which the buffer contents reveal as soon as the frame is checked. A wrong per-buffer counter or cap shows up as buffer lengths that do not match the programmed size, or as frame events raised at the wrong descriptor. A wrong current-descriptor pointer shows up within one frame as write-backs to the wrong ring slot, or as `rx_active` disagreeing with the empty flag of the slot that should come next. A source that does not discard data after truncation or a lost end would stall `in_ready` or leak bytes into the following frame.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive descriptor ring engine.
// Assumes descriptors are two little-endian 32-bit words:
// word 0 holds {flags[15:0], length[15:0]} and word 1 holds the buffer address.
package rxr_pkg;

    localparam int FLAG_EMPTY  = 15;
    localparam int FLAG_WRAP   = 13;
    localparam int FLAG_LAST   = 11;
    localparam int FLAG_LENERR = 5;
    localparam int FLAG_TRUNC  = 0;
    localparam int DESC_STRIDE = 8;
    localparam int LEN_W       = 11;

    typedef enum logic [2:0] {
        CT_IDLE,
        CT_RD_FLAGS,
        CT_RD_PTR,
        CT_GET_PTR,
        CT_FILL,
        CT_CLOSE,
        CT_PEEK,
        CT_PEEK_WAIT
    } ctl_state_e;

    typedef enum logic [1:0] {
        SR_FRAME,
        SR_FCS,
        SR_DISCARD
    } src_state_e;

endpackage

// File: rtl/rxr_crc32.sv
// Byte-serial Ethernet CRC-32 accumulator.
// Assumes the LSB of each byte is processed first (reflected polynomial).
// fcs shows the inverted running value, ready to append after the last update.
module rxr_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    localparam logic [31:0] POLY = 32'hEDB88320;

    logic [31:0] acc_q;
    logic [31:0] acc_nx;

    // Advance the accumulator by one byte, bit by bit.
    always_comb begin
        acc_nx = acc_q;
        for (int b = 0; b < 8; b++) begin
            if (acc_nx[0] ^ din[b]) acc_nx = (acc_nx >> 1) ^ POLY;
            else                    acc_nx = acc_nx >> 1;
        end
    end

    // Hold the accumulator; preset it at reset or at the start of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= '1;
        else if (clr) acc_q <= '1;
        else if (en)  acc_q <= acc_nx;
    end

    assign fcs = ~acc_q;
endmodule

// File: rtl/rxr_fcs_stream.sv
// Turns the incoming frame into the stored byte stream: frame bytes then
// four CRC bytes (MSB first), cut at MAX_FRAME bytes.
// After a cut or an abort, the remaining input bytes are consumed and dropped.
// Assumes the consumer asserts abort only in a cycle in which it takes no byte.
module rxr_fcs_stream #(
    parameter int MAX_FRAME = 1518,
    localparam int CW = $clog2(MAX_FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          abort,
    input  logic          s_take,
    output logic          s_valid,
    output logic [7:0]    s_byte,
    output logic          s_end,
    output logic          s_trunc,
    output logic [CW-1:0] s_size
);
    import rxr_pkg::*;

    src_state_e   st_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]   idx_q;
    logic [31:0]  fcs;
    logic         at_cap;
    logic         restart;
    logic         crc_en;

    assign at_cap = (cnt_q == CW'(MAX_FRAME - 1));
    assign s_size = cnt_q + CW'(1);

    rxr_crc32 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .en   (crc_en),
        .din  (in_data),
        .fcs  (fcs)
    );

    // Select the byte presented to the consumer and the input handshake.
    always_comb begin
        s_valid  = 1'b0;
        s_byte   = in_data;
        s_end    = 1'b0;
        s_trunc  = 1'b0;
        in_ready = 1'b0;
        unique case (st_q)
            SR_FRAME: begin
                s_valid  = in_valid;
                s_end    = at_cap;
                s_trunc  = at_cap;
                in_ready = s_take;
            end
            SR_FCS: begin
                s_valid = 1'b1;
                s_byte  = fcs[8*(3 - int'(idx_q)) +: 8];
                s_end   = at_cap || (idx_q == 2'd3);
                s_trunc = at_cap && (idx_q != 2'd3);
            end
            SR_DISCARD: begin
                in_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // Decide when the stream returns to its start state for the next frame.
    always_comb begin
        restart = 1'b0;
        unique case (st_q)
            SR_FRAME:   restart = s_take && at_cap && in_last;
            SR_FCS:     restart = abort || (s_take && s_end);
            SR_DISCARD: restart = in_valid && in_last;
            default:    restart = 1'b1;
        endcase
    end

    assign crc_en = (st_q == SR_FRAME) && s_take;

    // Sequence frame bytes, CRC bytes and discarding; count stored bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            st_q  <= SR_FRAME;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                SR_FRAME: begin
                    if (abort) begin
                        st_q <= SR_DISCARD;
                    end else if (s_take) begin
                        cnt_q <= cnt_q + CW'(1);
                        if (at_cap)       st_q <= SR_DISCARD;
                        else if (in_last) st_q <= SR_FCS;
                    end
                end
                SR_FCS: begin
                    if (s_take) begin
                        cnt_q <= cnt_q + CW'(1);
                        idx_q <= idx_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxr_ring_engine.sv
// Receive descriptor ring engine: scatters the stored stream into buffers
// named by a ring of 8-byte descriptors, writes back the length and flags,
// raises per-buffer and per-frame events and tracks receive-active.
// Assumes: single-cycle read latency on mem_rdata, every request accepted at
// once, ring_base 8-byte aligned, and a nonzero buffer cap while receiving.
module rxr_ring_engine #(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 1518
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_en,
    input  logic          rx_demand,
    input  logic          ring_set,
    input  logic [AW-1:0] ring_base,
    input  logic [15:0]   buf_max,
    input  logic [15:0]   len_limit,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          evt_buf,
    output logic          evt_frame,
    output logic          rx_active
);
    import rxr_pkg::*;

    localparam int CW = $clog2(MAX_FRAME + 1);

    ctl_state_e     st_q;
    logic [AW-1:0]  cur_q;
    logic [AW-1:0]  bptr_q;
    logic [15:0]    dflags_q;
    logic [LEN_W-1:0] bcnt_q;
    logic           last_q;
    logic           lerr_q;
    logic           trunc_q;
    logic           active_q;

    logic           s_valid, s_end, s_trunc, s_take, abort;
    logic [7:0]     s_byte;
    logic [CW-1:0]  s_size;
    logic [AW-1:0]  base_al;
    logic [LEN_W-1:0] cap;
    logic [AW-1:0]  byte_addr;
    logic [15:0]    close_flags;
    logic           cap_hit;
    logic           over_limit;

    assign base_al    = {ring_base[AW-1:2], 2'b00};
    assign cap        = {buf_max[10:4], 4'b0000};
    assign byte_addr  = bptr_q + AW'(bcnt_q);
    assign cap_hit    = (bcnt_q + LEN_W'(1)) == cap;
    assign over_limit = 17'(s_size) > 17'(len_limit);
    assign s_take     = (st_q == CT_FILL) && s_valid;
    assign abort      = (st_q == CT_RD_PTR) && !mem_rdata[16 + FLAG_EMPTY];

    rxr_fcs_stream #(.MAX_FRAME(MAX_FRAME)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_data (in_data),
        .in_last (in_last),
        .in_ready(in_ready),
        .abort   (abort),
        .s_take  (s_take),
        .s_valid (s_valid),
        .s_byte  (s_byte),
        .s_end   (s_end),
        .s_trunc (s_trunc),
        .s_size  (s_size)
    );

    // Build the flag half-word written back when a buffer closes.
    always_comb begin
        close_flags = dflags_q;
        close_flags[FLAG_EMPTY] = 1'b0;
        if (last_q) begin
            close_flags[FLAG_LAST] = 1'b1;
            if (lerr_q)  close_flags[FLAG_LENERR] = 1'b1;
            if (trunc_q) close_flags[FLAG_TRUNC]  = 1'b1;
        end
    end

    // Drive the memory port from the control state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_be    = 4'b0000;
        mem_wdata = '0;
        unique case (st_q)
            CT_RD_FLAGS, CT_PEEK: mem_req = 1'b1;
            CT_RD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'(4);
            end
            CT_FILL: begin
                mem_req   = s_valid;
                mem_we    = 1'b1;
                mem_addr  = byte_addr;
                mem_be    = 4'b0001 << byte_addr[1:0];
                mem_wdata = {4{s_byte}};
            end
            CT_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'b1111;
                mem_wdata = {close_flags, 16'(bcnt_q)};
            end
            default: ;
        endcase
    end

    // Walk the ring: fetch, fill, write back, advance, re-check the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CT_IDLE;
            cur_q    <= '0;
            bptr_q   <= '0;
            dflags_q <= '0;
            bcnt_q   <= '0;
            last_q   <= 1'b0;
            lerr_q   <= 1'b0;
            trunc_q  <= 1'b0;
            active_q <= 1'b0;
        end else begin
            unique case (st_q)
                CT_IDLE: begin
                    if (ring_set)                                cur_q <= base_al;
                    else if (active_q && s_valid)                st_q  <= CT_RD_FLAGS;
                    else if (rx_demand && ctrl_en && !active_q)  st_q  <= CT_PEEK;
                end
                CT_RD_FLAGS: st_q <= CT_RD_PTR;
                CT_RD_PTR: begin
                    dflags_q <= mem_rdata[31:16];
                    if (abort) begin
                        active_q <= 1'b0;
                        st_q     <= CT_IDLE;
                    end else begin
                        st_q <= CT_GET_PTR;
                    end
                end
                CT_GET_PTR: begin
                    bptr_q <= mem_rdata[AW-1:0];
                    bcnt_q <= '0;
                    last_q <= 1'b0;
                    st_q   <= CT_FILL;
                end
                CT_FILL: begin
                    if (s_take) begin
                        bcnt_q <= bcnt_q + LEN_W'(1);
                        if (s_end) begin
                            last_q  <= 1'b1;
                            trunc_q <= s_trunc;
                            lerr_q  <= s_trunc || over_limit;
                            st_q    <= CT_CLOSE;
                        end else if (cap_hit) begin
                            st_q <= CT_CLOSE;
                        end
                    end
                end
                CT_CLOSE: begin
                    cur_q <= dflags_q[FLAG_WRAP] ? base_al : cur_q + AW'(DESC_STRIDE);
                    st_q  <= last_q ? CT_PEEK : CT_RD_FLAGS;
                end
                CT_PEEK: st_q <= CT_PEEK_WAIT;
                CT_PEEK_WAIT: begin
                    active_q <= ctrl_en && mem_rdata[16 + FLAG_EMPTY];
                    st_q     <= CT_IDLE;
                end
                default: st_q <= CT_IDLE;
            endcase
            if (!ctrl_en) active_q <= 1'b0;
        end
    end

    assign evt_buf   = (st_q == CT_CLOSE) && !last_q;
    assign evt_frame = (st_q == CT_CLOSE) && last_q;
    assign rx_active = active_q;
endmodule

// File: rtl/rxr_ring_engine_chk.sv
// Port-level properties of the receive ring engine, bound to every instance.
// Assumes the buffer cap is held stable while a frame is stored.
module rxr_ring_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_en,
    input logic [15:0]   buf_max,
    input logic          mem_req,
    input logic          mem_we,
    input logic [3:0]    mem_be,
    input logic [31:0]   mem_wdata,
    input logic          evt_buf,
    input logic          evt_frame,
    input logic          rx_active
);
    // R4
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_buf && evt_frame));

    // R4
    frame_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame |-> (mem_req && mem_we && mem_be == 4'hF && mem_wdata[27] && !mem_wdata[31]));

    // R3
    buf_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf |-> (mem_req && mem_we && mem_be == 4'hF && !mem_wdata[27] && !mem_wdata[31]));

    // R11
    en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !rx_active);

    // R2
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_buf || evt_frame) && buf_max[10:4] != 7'd0)
        |-> (mem_wdata[15:0] <= {5'd0, buf_max[10:4], 4'd0}));

    // R1
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

    // R5
    trunc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_frame && mem_wdata[16]) |-> mem_wdata[21]);
endmodule

bind rxr_ring_engine rxr_ring_engine_chk #(.AW(AW)) u_rxr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_en  (ctrl_en),
    .buf_max  (buf_max),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata),
    .evt_buf  (evt_buf),
    .evt_frame(evt_frame),
    .rx_active(rx_active)
);

// File: tb/rxr_ring_engine_bench.sv
module rxr_ring_engine_bench;
    localparam int MAXF = 100;
    localparam int MEMB = 4096;
    localparam int RING = 'h100;
    localparam int BUFA = 'h400;
    localparam int NV   = 11;
    // {len[63:48], buf_max[47:32], limit[31:16], bufs[15:8], tr[4], lg[0]}
    localparam logic [63:0] VEC [NV] = '{
        {16'd10,  16'h0040, 16'd200, 8'd1, 8'h00},
        {16'd60,  16'h0020, 16'd200, 8'd2, 8'h00},
        {16'd30,  16'h0020, 16'd200, 8'd2, 8'h00},
        {16'd29,  16'h0020, 16'd200, 8'd2, 8'h00},
        {16'd50,  16'h0010, 16'd40,  8'd4, 8'h01},
        {16'd36,  16'h0010, 16'd40,  8'd3, 8'h00},
        {16'd120, 16'h0030, 16'd200, 8'd3, 8'h11},
        {16'd96,  16'h0030, 16'd200, 8'd3, 8'h00},
        {16'd97,  16'h0030, 16'd200, 8'd3, 8'h11},
        {16'd60,  16'h083F, 16'd200, 8'd2, 8'h00},
        {16'd40,  16'h07F5, 16'd200, 8'd1, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctrl_en = 1'b0, rx_demand = 1'b0, ring_set = 1'b0;
    logic [31:0] ring_base = RING;
    logic [15:0] buf_max = 16'h0040, len_limit = 16'd200;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0] in_data = 8'h00;
    logic mem_req, mem_we, evt_buf, evt_frame, rx_active;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic [3:0] mem_be;

    logic [7:0] bmem [MEMB];
    logic hw_clr = 1'b0, hw_en = 1'b0;
    logic [11:0] hw_addr = '0;
    logic [31:0] hw_data = '0;
    logic ev_clr = 1'b0;
    int nbuf_ev = 0, nfrm_ev = 0;
    int checks = 0, failures = 0;
    logic [7:0] expst [256];

    always #4 clk = ~clk;

    rxr_ring_engine #(.AW(32), .MAX_FRAME(MAXF)) u_rxr_ring_engine (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .rx_demand(rx_demand),
        .ring_set(ring_set), .ring_base(ring_base), .buf_max(buf_max),
        .len_limit(len_limit), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .evt_buf(evt_buf),
        .evt_frame(evt_frame), .rx_active(rx_active)
    );

    // Byte memory with one-cycle reads plus a bench-side loading port.
    always @(posedge clk) begin
        if (hw_clr) begin
            for (int i = 0; i < MEMB; i++) bmem[i] <= 8'h00;
        end else if (hw_en) begin
            for (int b = 0; b < 4; b++) bmem[int'(hw_addr) + b] <= hw_data[8*b +: 8];
        end
        if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) bmem[int'({mem_addr[11:2], 2'b00}) + b] <= mem_wdata[8*b +: 8];
        end
        if (mem_req && !mem_we) begin
            for (int b = 0; b < 4; b++)
                mem_rdata[8*b +: 8] <= bmem[int'(mem_addr[11:0]) + b];
        end
    end

    // Event counters.
    always @(posedge clk) begin
        if (ev_clr) begin
            nbuf_ev <= 0;
            nfrm_ev <= 0;
        end else begin
            if (evt_buf)   nbuf_ev <= nbuf_ev + 1;
            if (evt_frame) nfrm_ev <= nfrm_ev + 1;
        end
    end

    function automatic logic [31:0] rd32(input int a);
        return {bmem[a+3], bmem[a+2], bmem[a+1], bmem[a]};
    endfunction

    function automatic logic [7:0] pat(input int v, input int i);
        return 8'((i * 7 + v * 13 + 1) & 255);
    endfunction

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic host_wr(input int a, input logic [31:0] d);
        @(negedge clk); hw_en = 1'b1; hw_addr = 12'(a); hw_data = d;
        @(negedge clk); hw_en = 1'b0;
    endtask

    // Clear memory and lay out ndesc empty descriptors, the last one wrapping.
    task automatic setup_ring(input int ndesc);
        @(negedge clk); hw_clr = 1'b1;
        @(negedge clk); hw_clr = 1'b0;
        for (int d = 0; d < 8; d++) begin
            logic [15:0] fl;
            fl = (d < ndesc) ? 16'h8000 : 16'h0000;
            if (d == ndesc - 1) fl = fl | 16'h2000;
            host_wr(RING + 8*d, {fl, 16'h0});
            host_wr(RING + 8*d + 4, BUFA + 'h100*d);
        end
    endtask

    // Point the engine at the ring base, enable it and request receive.
    task automatic arm();
        @(negedge clk); ctrl_en = 1'b0;
        @(negedge clk); ring_set = 1'b1;
        @(negedge clk); ring_set = 1'b0; ctrl_en = 1'b1; rx_demand = 1'b1;
        @(negedge clk); rx_demand = 1'b0; ev_clr = 1'b1;
        @(negedge clk); ev_clr = 1'b0;
        tick(3);
    endtask

    task automatic send_frame(input int v, input int n);
        int i = 0;
        while (i < n) begin
            logic rdy;
            @(negedge clk);
            in_valid = 1'b1; in_data = pat(v, i); in_last = (i == n - 1);
            #1 rdy = in_ready;
            @(posedge clk);
            if (rdy) i++;
        end
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
        tick(10);
        @(negedge clk);
    endtask

    // Expected stored stream: frame bytes, CRC MSB first, cut at MAXF.
    task automatic build_exp(input int v, input int n, output int stored);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) c = crc_step(c, pat(v, i));
        c = ~c;
        for (int i = 0; i < 256; i++) begin
            if (i < n)          expst[i] = pat(v, i);
            else if (i < n + 4) expst[i] = c[8*(3 - (i - n)) +: 8];
            else                expst[i] = 8'h00;
        end
        stored = (n + 4 > MAXF) ? MAXF : n + 4;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk); in_valid = 1'b1; in_last = 1'b1;
        #1;
        // R12 reset state
        chk(rx_active == 1'b0, "R12 reset rx_active", rx_active, 0);
        chk(in_ready == 1'b0, "R12 reset in_ready", in_ready, 0);
        chk(!evt_buf && !evt_frame, "R12 reset events", {evt_buf, evt_frame}, 0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0; in_last = 1'b0;
        tick(2);

        // R10 demand while disabled has no effect; R12 no accept while inactive
        setup_ring(8);
        @(negedge clk); ring_set = 1'b1;
        @(negedge clk); ring_set = 1'b0; rx_demand = 1'b1;
        @(negedge clk); rx_demand = 1'b0;
        tick(4);
        @(negedge clk); in_valid = 1'b1; #1;
        chk(rx_active == 1'b0, "R10 demand while disabled", rx_active, 0);
        chk(in_ready == 1'b0, "R12 in_ready while inactive", in_ready, 0);
        @(negedge clk); in_valid = 1'b0;

        // Vector table: R1 R2 R3 R4 R5 R6 R9 R10
        for (int v = 0; v < NV; v++) begin
            int n, cap, stored, nb, off, bad;
            logic tr, lg;
            n = int'(VEC[v][63:48]);
            nb = int'(VEC[v][15:8]);
            tr = VEC[v][4];
            lg = VEC[v][0];
            setup_ring(8);
            @(negedge clk); buf_max = VEC[v][47:32]; len_limit = VEC[v][31:16];
            cap = int'({VEC[v][42:36], 4'b0});
            arm();
            chk(rx_active == 1'b1, "R10 demand arms receive", rx_active, 1);
            build_exp(v, n, stored);
            send_frame(v, n);
            chk(nbuf_ev == nb - 1, "R4 buffer events", nbuf_ev, nb - 1);
            chk(nfrm_ev == 1, "R4 frame event", nfrm_ev, 1);
            off = 0;
            bad = 0;
            for (int k = 0; k < nb; k++) begin
                int l;
                logic [15:0] ef;
                l = (stored - off > cap) ? cap : stored - off;
                ef = (k == nb - 1) ? (16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0)) : 16'h0;
                chk(rd32(RING + 8*k) == {ef, 16'(l)}, "R3 R5 R6 descriptor write-back",
                    rd32(RING + 8*k), {ef, 16'(l)});
                for (int j = 0; j < l; j++)
                    if (bmem[BUFA + 'h100*k + j] != expst[off + j]) bad++;
                off += l;
            end
            chk(bad == 0, "R1 R2 stored bytes", bad, 0);
            chk(rd32(RING + 8*nb) == 32'h8000_0000, "R2 next descriptor untouched",
                rd32(RING + 8*nb), 32'h8000_0000);
            chk(rx_active == 1'b1, "R9 next descriptor empty", rx_active, 1);
        end

        // R11 enable drop clears receive-active
        @(negedge clk); ctrl_en = 1'b0;
        @(negedge clk);
        chk(rx_active == 1'b0, "R11 enable low", rx_active, 0);

        // R7 wrap to base, R9 inactive when next slot is full
        setup_ring(2);
        @(negedge clk); buf_max = 16'h0020; len_limit = 16'd200;
        arm();
        send_frame(1, 60);
        chk(rd32(RING) == 32'h0000_0020, "R3 first slot write-back", rd32(RING), 32'h0000_0020);
        chk(rd32(RING + 8) == 32'h2800_0020, "R3 wrap flag kept", rd32(RING + 8), 32'h2800_0020);
        chk(rx_active == 1'b0, "R9 next descriptor full", rx_active, 0);
        host_wr(RING, 32'h8000_0000);
        @(negedge clk); rx_demand = 1'b1;
        @(negedge clk); rx_demand = 1'b0;
        tick(4);
        chk(rx_active == 1'b1, "R10 re-arm after refill", rx_active, 1);
        send_frame(0, 10);
        chk(rd32(RING) == 32'h0800_000E, "R7 ring wrapped to base", rd32(RING), 32'h0800_000E);

        // R8 lost end of frame at a full descriptor
        setup_ring(3);
        host_wr(RING + 8, 32'h0000_0000);
        @(negedge clk); buf_max = 16'h0020;
        arm();
        send_frame(2, 60);
        chk(rd32(RING) == 32'h0000_0020, "R8 first buffer closed", rd32(RING), 32'h0000_0020);
        chk(rd32(RING + 8) == 32'h0, "R8 full descriptor untouched", rd32(RING + 8), 0);
        chk(bmem[BUFA + 'h100] == 8'h00, "R8 no data past stop", bmem[BUFA + 'h100], 0);
        chk(nbuf_ev == 1 && nfrm_ev == 0, "R8 events", {nbuf_ev[7:0], nfrm_ev[7:0]}, 16'h0100);
        @(negedge clk); in_valid = 1'b1; #1;
        chk(rx_active == 1'b0 && in_ready == 1'b0, "R8 receive stopped", {rx_active, in_ready}, 0);
        @(negedge clk); in_valid = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule